// File: doc/BRIEF.md
# Two-Pass Subranging Conversion Sequencer

This block runs the digital side of an 8-bit analog-to-digital conversion made in two passes of 4 bits each. One bank of 16 comparators serves both passes. A start request opens a fixed sequence of phases. First the input is sampled while the comparators auto-zero. Then the sampler holds, and the bank makes a coarse comparison against the full-scale ladder. After that the bank makes a fine comparison of the residue, using steps one sixteenth as large. Each phase lasts a number of clock cycles set by a parameter.

At the end of the coarse pass the block latches the bank's thermometer code and reduces it to a 4-bit count. That count drives the residue DAC directly and stays fixed through the fine pass. At the end of the fine pass the block writes the whole 8-bit code to the result register in one edge and pulses `done`. In the same cycle the sampler goes back to acquiring.

A broken thermometer code, with a zero below a one, is resolved by counting the ones. The block then raises an error flag that travels with the result. The comparators, the ladder and the DAC lie outside the block.

Top module: `subrange_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `ctl_zero`, `ctl_hold`, `ctl_coarse`, `ctl_fine`, `done`, `bubble_err`, `dac_word` and `result` are all zero.
- R2: A `start` high at a clock edge while the block is idle puts the block in the zero phase from that edge. In the zero phase `ctl_zero` is high and `ctl_hold` is low, for exactly ZERO_CYC cycles.
- R3: The coarse phase follows the zero phase directly. In the coarse phase `ctl_hold` and `ctl_coarse` are high for exactly COARSE_CYC cycles.
- R4: On the last edge of the coarse phase, `dac_word` takes the coarse code. It then stays unchanged through the whole fine phase and until the next coarse pass ends.
- R5: The fine phase follows the coarse phase directly. In the fine phase `ctl_hold` and `ctl_fine` are high for exactly FINE_CYC cycles.
- R6: On the last edge of the fine phase, `result` takes {coarse code, fine code} with the coarse code in bits 7:4. `done` is high for exactly that one following cycle, and `ctl_hold` is already low in that cycle.
- R7: A pass code is the number of ones in `cmp_vec`, limited to 15. Bit k of `cmp_vec` is the comparator on tap k+1, with bit 0 the lowest tap. All 16 ones therefore give 15.
- R8: If some bit k≥1 of `cmp_vec` is one while bit k-1 is zero in either pass, the code is still the count of ones and `bubble_err` is high alongside that result. A conversion with clean codes in both passes clears `bubble_err`.
- R9: `start` has no effect while a conversion is in progress. After the conversion the block stays idle.
- R10: With comparators that include a half-LSB offset, the result for an input v (in LSB) is min(floor(v+0.5), 255) across the whole input range.
- R11: `result` keeps its value between `done` pulses. A `start` given in the `done` cycle is accepted, and the previous result stays visible during the new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, taken only while idle |
| cmp_vec | input | 16 | Comparator bank outputs, bit k for tap k+1 |
| ctl_zero | output | 1 | Auto-zero with input sampling |
| ctl_hold | output | 1 | Sampler in hold |
| ctl_coarse | output | 1 | Bank on coarse taps |
| ctl_fine | output | 1 | Bank on fine taps plus residue |
| dac_word | output | 4 | Residue DAC code from the coarse pass |
| result | output | 8 | Latched conversion result |
| done | output | 1 | One-cycle pulse when `result` updates |
| bubble_err | output | 1 | Broken thermometer code seen in the last conversion |

## Verification
Two events can fall in the same cycle. The result load, with `done` and the return to acquire, can coincide with a fresh `start`. The input sweep provokes this by raising `start` in the very cycle `done` is seen, so every conversion after the first follows its predecessor back to back. Each chained conversion is judged on three points: the zero phase must begin at once, the previous result must stay on `result` through the new conversion, and the new result must appear only at its own `done`. A second overlap puts a `start` inside the coarse phase. There the phase lengths must come out unchanged and the block must go idle after `done`.

// File: rtl/subrange_pkg.sv
// Shared types for the subranging sequencer.
// Assumes: the phases are visited strictly in enum order after idle.
package subrange_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ZERO   = 2'd1,
        PH_COARSE = 2'd2,
        PH_FINE   = 2'd3
    } phase_e;
endpackage

// File: rtl/therm_decode.sv
// Reduces a comparator thermometer vector to a saturated count of ones and
// flags a vector whose ones are not contiguous from bit 0.
// Assumes: bit 0 is the lowest tap; CODE_W bits hold the saturated count.
module therm_decode #(
    parameter int CODE_W = 4
) (
    input  logic [(2**CODE_W)-1:0] vec,
    output logic [CODE_W-1:0]      code,
    output logic                   bubble
);
    localparam int N       = 2**CODE_W;
    localparam int SUM_W   = CODE_W + 1;
    localparam int SAT_VAL = N - 1;

    logic [N-1:0]     gap;
    logic [SUM_W-1:0] ones;

    // Mark each bit that is set above a clear neighbour.
    assign gap[0] = 1'b0;
    generate
        for (genvar k = 1; k < N; k++) begin : g_gap
            assign gap[k] = vec[k] & ~vec[k-1];
        end
    endgenerate

    // Count the ones and saturate to the code range.
    always_comb begin
        ones = '0;
        for (int k = 0; k < N; k++) begin
            ones = ones + SUM_W'(vec[k]);
        end
        if (ones > SUM_W'(SAT_VAL)) code = CODE_W'(SAT_VAL);
        else                        code = ones[CODE_W-1:0];
        bubble = |gap;
    end

    // R7: a clean, unsaturated vector decodes to its population count.
    always_comb begin
        if (!bubble && vec != '1)
            a_r7_clean_count: assert (int'(code) == $countones(vec));
    end
endmodule

// File: rtl/phase_ctrl.sv
// Phase sequencer: idle -> zero -> coarse -> fine -> idle, each phase a
// parameterised number of cycles. Start is taken only in idle.
// Assumes: every phase length is at least 1.
module phase_ctrl
    import subrange_pkg::*;
#(
    parameter int ZERO_CYC   = 2,
    parameter int COARSE_CYC = 3,
    parameter int FINE_CYC   = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   phase_end
);
    localparam int MAX_A   = (ZERO_CYC > COARSE_CYC) ? ZERO_CYC : COARSE_CYC;
    localparam int MAX_LEN = (MAX_A > FINE_CYC) ? MAX_A : FINE_CYC;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;
    phase_e           nxt;

    // Length of the current phase and the phase that follows it.
    always_comb begin
        case (phase)
            PH_ZERO:   begin len = CNT_W'(ZERO_CYC);   nxt = PH_COARSE; end
            PH_COARSE: begin len = CNT_W'(COARSE_CYC); nxt = PH_FINE;   end
            PH_FINE:   begin len = CNT_W'(FINE_CYC);   nxt = PH_IDLE;   end
            default:   begin len = CNT_W'(1);          nxt = PH_IDLE;   end
        endcase
        phase_end = (phase != PH_IDLE) && (cnt == len - CNT_W'(1));
    end

    // Phase register and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (start) phase <= PH_ZERO;
        end else if (phase_end) begin
            cnt   <= '0;
            phase <= nxt;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    a_r2_start_enters_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start) |=> (phase == PH_ZERO));
    a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COARSE) |=> (phase == PH_COARSE || phase == PH_FINE));
    a_r5_fine_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FINE && phase_end) |=> (phase == PH_IDLE));
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (cnt < len));
endmodule

// File: rtl/subrange_seq.sv
// Two-pass subranging conversion sequencer. One comparator bank is decoded
// on the coarse and the fine pass; the coarse code drives the residue DAC and
// the two codes form the result, loaded in one edge with a done pulse.
// Assumes: cmp_vec is settled by the last cycle of each comparison phase.
module subrange_seq
    import subrange_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int ZERO_CYC   = 2,
    parameter int COARSE_CYC = 3,
    parameter int FINE_CYC   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [(2**CODE_W)-1:0] cmp_vec,
    output logic                  ctl_zero,
    output logic                  ctl_hold,
    output logic                  ctl_coarse,
    output logic                  ctl_fine,
    output logic [CODE_W-1:0]     dac_word,
    output logic [2*CODE_W-1:0]   result,
    output logic                  done,
    output logic                  bubble_err
);
    phase_e            phase;
    logic              phase_end;
    logic [CODE_W-1:0] pass_code;
    logic              pass_bubble;
    logic              coarse_bubble;

    phase_ctrl #(
        .ZERO_CYC  (ZERO_CYC),
        .COARSE_CYC(COARSE_CYC),
        .FINE_CYC  (FINE_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .phase    (phase),
        .phase_end(phase_end)
    );

    therm_decode #(.CODE_W(CODE_W)) u_dec (
        .vec   (cmp_vec),
        .code  (pass_code),
        .bubble(pass_bubble)
    );

    // Phase controls towards the analog core.
    always_comb begin
        ctl_zero   = (phase == PH_ZERO);
        ctl_coarse = (phase == PH_COARSE);
        ctl_fine   = (phase == PH_FINE);
        ctl_hold   = ctl_coarse | ctl_fine;
    end

    // Coarse latch: DAC code and its bubble flag at the end of the coarse pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word      <= '0;
            coarse_bubble <= 1'b0;
        end else if (phase == PH_COARSE && phase_end) begin
            dac_word      <= pass_code;
            coarse_bubble <= pass_bubble;
        end
    end

    // Output latch: whole result, error flag and done pulse after the fine pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            bubble_err <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= (phase == PH_FINE) && phase_end;
            if (phase == PH_FINE && phase_end) begin
                result     <= {dac_word, pass_code};
                bubble_err <= coarse_bubble | pass_bubble;
            end
        end
    end

    a_r4_dac_steady_in_fine: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_fine |=> $stable(dac_word));
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_acquire_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ctl_hold);
    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    a_r6_upper_from_dac: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[2*CODE_W-1:CODE_W] == dac_word));
endmodule

// File: tb/subrange_seq_tb.sv
`timescale 1ns/1ps
// Bench: comparator-bank model with half-LSB offset, full input sweep in
// half-LSB steps, injected thermometer vectors and overlapping starts.
module subrange_seq_tb;
    localparam int ZC = 2;
    localparam int CC = 3;
    localparam int FC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cmp_vec;
    logic        ctl_zero, ctl_hold, ctl_coarse, ctl_fine, done, bubble_err;
    logic [3:0]  dac_word;
    logic [7:0]  result;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          vin2    = 0;      // input in half-LSB units
    bit          inject  = 1'b0;
    logic [15:0] inj_c   = '0;
    logic [15:0] inj_f   = '0;

    always #2 clk = ~clk;

    subrange_seq #(.CODE_W(4), .ZERO_CYC(ZC), .COARSE_CYC(CC), .FINE_CYC(FC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_vec(cmp_vec),
        .ctl_zero(ctl_zero), .ctl_hold(ctl_hold), .ctl_coarse(ctl_coarse),
        .ctl_fine(ctl_fine), .dac_word(dac_word), .result(result),
        .done(done), .bubble_err(bubble_err)
    );

    // Comparator bank model; half-LSB offset = +1 in half-LSB units.
    always_comb begin
        cmp_vec = '0;
        for (int k = 0; k < 16; k++) begin
            if (ctl_coarse)
                cmp_vec[k] = inject ? inj_c[k] : (vin2 + 1 >= 32 * (k + 1));
            else if (ctl_fine)
                cmp_vec[k] = inject ? inj_f[k]
                           : (vin2 + 1 - 32 * int'(dac_word) >= 2 * (k + 1));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_ones(input logic [15:0] v);
        int c = 0;
        for (int k = 0; k < 16; k++) c += int'(v[k]);
        return (c > 15) ? 15 : c;
    endfunction

    function automatic bit has_gap(input logic [15:0] v);
        for (int k = 1; k < 16; k++) if (v[k] && !v[k-1]) return 1'b1;
        return 1'b0;
    endfunction

    // One conversion; when chained the call is made at the done negedge.
    task automatic conv(input int exp_res, input int exp_c, input bit exp_err,
                        input bit chained, input bit busy_kick);
        int nz = 0, nc = 0, nf = 0, n = 0;
        logic [7:0] prev;
        bit kicked = 1'b0;
        if (!chained) @(negedge clk);
        prev  = result;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ctl_zero && !ctl_hold, "R2 zero phase after start", ctl_zero, 1);
        if (chained) chk(result == prev, "R11 result kept in chained start", result, prev);
        while (!done && n < 100) begin
            if (ctl_zero) nz++;
            if (ctl_coarse && ctl_hold) nc++;
            if (ctl_fine && ctl_hold) nf++;
            if (ctl_fine && dac_word != 4'(exp_c))
                chk(1'b0, "R4 dac steady in fine", dac_word, exp_c);
            if (!done && result != prev)
                chk(1'b0, "R11 result held mid-conversion", result, prev);
            if (busy_kick && ctl_coarse && !kicked) begin
                start = 1'b1; kicked = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(nz == ZC, "R2 zero phase length", nz, ZC);
        chk(nc == CC, "R3 coarse phase length", nc, CC);
        chk(nf == FC, "R5 fine phase length", nf, FC);
        chk(done && !ctl_hold, "R6 done with sampler acquiring", ctl_hold, 0);
        chk(result == 8'(exp_res), "R6 R10 result", result, exp_res);
        chk(bubble_err == exp_err, "R8 bubble flag", bubble_err, exp_err);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #800000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        chk({ctl_zero, ctl_hold, ctl_coarse, ctl_fine, done, bubble_err} == '0,
            "R1 controls in reset", {ctl_zero, ctl_hold, ctl_coarse, ctl_fine}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result == 0 && dac_word == 0 && !done, "R1 registers after reset", result, 0);

        // R10 / R11: full sweep, each conversion started in the previous done cycle.
        for (int v = 0; v < 512; v++) begin
            vin2 = v;
            e = (v + 1) / 2;
            if (e > 255) e = 255;
            conv(e, e / 16, 1'b0, v != 0, 1'b0);
        end
        @(negedge clk);
        chk(!done, "R6 done lasts one cycle", done, 0);

        // R7: all sixteen ones saturate at 15 in both passes.
        inject = 1'b1; inj_c = 16'hFFFF; inj_f = 16'hFFFF;
        conv(255, 15, 1'b0, 1'b0, 1'b0);
        chk(sat_ones(16'hFFFF) == 15, "R7 bench saturation", sat_ones(16'hFFFF), 15);

        // R8: bubbles in each pass resolved by counting ones.
        inj_c = 16'h0005; inj_f = 16'h00F0;
        conv(sat_ones(inj_c) * 16 + sat_ones(inj_f), sat_ones(inj_c),
             has_gap(inj_c) | has_gap(inj_f), 1'b0, 1'b0);
        inj_c = 16'h0007; inj_f = 16'h8001;
        conv(3 * 16 + 2, 3, 1'b1, 1'b0, 1'b0);
        inj_c = 16'h0000; inj_f = 16'h0000;
        conv(0, 0, 1'b0, 1'b0, 1'b0);
        inject = 1'b0;

        // R8: clean conversion clears the flag; R9: start during coarse ignored.
        vin2 = 300;
        conv(150, 9, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!ctl_zero && !ctl_hold, "R9 idle after ignored start", ctl_zero, 0);
        end
        chk(result == 150, "R11 result held while idle", result, 150);
        chk(dac_word == 9, "R4 dac kept after conversion", dac_word, 9);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule